// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the boundary-scan cell for one bidirectional digital I/O pin. It sits between the core's port logic (data bit, direction bit, pull-up control and an optional system-clock output) and the pad. It is controlled by strobes from a test access port controller: capture, shift and update of the data register, a synchronous test-logic reset, and two decoded instruction flags for EXTEST and SAMPLE_PRELOAD. The TAP state machine and the instruction decode are outside this block.

One pin needs three scan values: output enable, output data and input data. The cell holds them in a two-stage scan register. The control stage captures the core's output enable. The data stage captures the raw pad level, with no synchronizer in front of it, and under EXTEST it supplies the output data. Behind the scan register is an update stage clocked on the falling TCK edge. Under EXTEST the update stage drives the pad. Under every other instruction the core's values pass through. While either scan instruction is active, the pull-up is forced off and the system clock is kept off the pin.

Top module: `bscan_pin_cell`

## Requirements
- R1: After the asynchronous reset `rst_n`, both scan stages and both update latches are 0. Under EXTEST the pad is therefore undriven (`pad_oe`=0, `pad_do`=0) and `scan_out`=0.
- R2: With neither scan instruction active and `clk_drive_cfg`=0, `pad_oe` equals `core_dir` and `pad_do` equals `core_dat`.
- R3: With neither scan instruction active, `pad_pullup` = (not `pullup_off_all`) AND (not `core_dir`) AND `core_dat`.
- R4: While `ins_extest` or `ins_sample` is 1, `pad_pullup` is 0 for every core setting.
- R5: With no scan instruction and `clk_drive_cfg`=1, `pad_oe`=1 and `pad_do` follows `sys_clk`. Under SAMPLE_PRELOAD, `clk_drive_cfg` has no effect and the pad shows `core_dir`/`core_dat`.
- R6: On a rising TCK edge with `capture_dr`=1, the control stage (position 0) loads `core_dir` and the data stage (position 1) loads the unsynchronized `pad_in`. Bit position 0 is the stage nearest `scan_in`.
- R7: On a rising TCK edge with `shift_dr`=1 and `capture_dr`=0, position 0 loads `scan_in` and position 1 loads position 0. `scan_out` always shows position 1.
- R8: When `capture_dr` and `shift_dr` are both 1, the capture takes place and the shift does not.
- R9: On a falling TCK edge with `update_dr`=1 and `tlr`=0, the update output-enable latch loads position 0 and the update data latch loads position 1. Without `update_dr`, shifting has no effect on the latches.
- R10: While `ins_extest` is 1 (priority over `ins_sample`), `pad_oe` and `pad_do` come from the update latches, whatever the core and clock settings are.
- R11: Under SAMPLE_PRELOAD the pad follows the core. A capture in that mode records the pad level present at that TCK edge.
- R12: On a falling TCK edge with `tlr`=1, both update latches clear to 0, overriding `update_dr`. Under EXTEST the pin then returns to undriven input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset of all cell state |
| tlr | input | 1 | Test-logic-reset state, synchronous clear of the update latches |
| ins_extest | input | 1 | Decoded EXTEST instruction active |
| ins_sample | input | 1 | Decoded SAMPLE_PRELOAD instruction active |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| scan_in | input | 1 | Serial data from the previous cell |
| scan_out | output | 1 | Serial data to the next cell |
| core_dat | input | 1 | Core port data bit |
| core_dir | input | 1 | Core direction bit (1 = output) |
| pullup_off_all | input | 1 | Global pull-up disable |
| clk_drive_cfg | input | 1 | Configuration asks for system clock on this pin |
| sys_clk | input | 1 | System clock to be driven out when enabled |
| pad_in | input | 1 | Raw pad level |
| pad_oe | output | 1 | Pad output enable |
| pad_do | output | 1 | Pad output data |
| pad_pullup | output | 1 | Pad pull-up enable |

## Verification
A wrong bit in a scan stage shows at `scan_out` no later than the following shift edges, so every capture is read back in the cycle after it. A wrong bit in an update latch shows at the pad as soon as EXTEST is selected. The bench holds EXTEST across updates so that a bad load or a missing hold appears in the same half cycle. A mode gating fault shows at once on `pad_pullup` or on the clock-output path, because those outputs are combinational in the instruction flags.

// File: rtl/bscan_cell_pkg.sv
package bscan_cell_pkg;
  localparam int CHAIN_LEN = 2;
  localparam int CTL_POS   = 0;
  localparam int DAT_POS   = 1;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_EXTEST = 2'd2
  } scan_mode_e;

  typedef struct packed {
    logic oe;
    logic dat;
  } drive_t;

  function automatic scan_mode_e decode_mode(input logic extest, input logic sample);
    if (extest)      return MODE_EXTEST;
    else if (sample) return MODE_SAMPLE;
    else             return MODE_FUNC;
  endfunction

  function automatic logic pullup_on(input scan_mode_e m, input logic off_all,
                                     input logic dir, input logic dat);
    return (m == MODE_FUNC) && !off_all && !dir && dat;
  endfunction

  function automatic drive_t pick_drive(input scan_mode_e m, input drive_t core,
                                        input drive_t upd, input logic clk_cfg,
                                        input logic clk);
    drive_t r;
    case (m)
      MODE_EXTEST: r = upd;
      MODE_SAMPLE: r = core;
      default:     r = clk_cfg ? '{oe: 1'b1, dat: clk} : core;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bsc_scan_stages.sv
module bsc_scan_stages #(
  parameter int N = bscan_cell_pkg::CHAIN_LEN
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         scan_in,
  input  logic [N-1:0] cap_vec,
  output logic [N-1:0] chain,
  output logic         scan_out
);
  logic [N-1:0] shift_src;
  logic [N-1:0] nxt;
  logic         cap_ev;
  logic         shf_ev;

  assign cap_ev = capture_dr;
  assign shf_ev = shift_dr && !capture_dr;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign shift_src[gi] = scan_in;
      end else begin : g_body
        assign shift_src[gi] = chain[gi-1];
      end
      assign nxt[gi] = cap_ev ? cap_vec[gi] : (shf_ev ? shift_src[gi] : chain[gi]);
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= nxt;
  end

  assign scan_out = chain[N-1];

  // R6 R8
  cap_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> (chain == $past(cap_vec)));
  // R7
  shift_walk_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> (chain == {$past(chain[N-2:0]), $past(scan_in)}));
  // R7
  idle_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(chain));
endmodule

// File: rtl/bsc_update_latch.sv
module bsc_update_latch #(
  parameter int N = bscan_cell_pkg::CHAIN_LEN
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         tlr,
  input  logic         update_dr,
  input  logic [N-1:0] chain,
  output logic [N-1:0] upd
);
  logic clr_ev;
  logic load_ev;

  assign clr_ev  = tlr;
  assign load_ev = update_dr && !tlr;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)       upd <= '0;
    else if (clr_ev)  upd <= '0;
    else if (load_ev) upd <= chain;
  end

  // R12
  tlr_clear_chk: assert property (@(posedge tck) disable iff (!rst_n)
    clr_ev |-> (upd == '0));
  // R9
  upd_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    load_ev |-> (upd == chain));
  // R9
  upd_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
    (!update_dr && !tlr) |=> $stable(upd));
endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux
  import bscan_cell_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic ins_extest,
  input  logic ins_sample,
  input  logic core_dat,
  input  logic core_dir,
  input  logic pullup_off_all,
  input  logic clk_drive_cfg,
  input  logic sys_clk,
  input  logic upd_oe,
  input  logic upd_dat,
  output logic pad_oe,
  output logic pad_do,
  output logic pad_pullup
);
  scan_mode_e mode;
  drive_t     core_drv;
  drive_t     upd_drv;
  drive_t     out_drv;
  logic       scan_active;

  assign mode        = decode_mode(ins_extest, ins_sample);
  assign scan_active = (mode != MODE_FUNC);
  assign core_drv    = '{oe: core_dir, dat: core_dat};
  assign upd_drv     = '{oe: upd_oe, dat: upd_dat};
  assign out_drv     = pick_drive(mode, core_drv, upd_drv, clk_drive_cfg, sys_clk);

  assign pad_oe     = out_drv.oe;
  assign pad_do     = out_drv.dat;
  assign pad_pullup = pullup_on(mode, pullup_off_all, core_dir, core_dat);

  // R4
  scan_pullup_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ins_extest || ins_sample) |-> !pad_pullup);
  // R5 R11
  sample_no_clk_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ins_sample && !ins_extest) |-> (pad_oe == core_dir && pad_do == core_dat));
  // R2
  func_pass_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!scan_active && !clk_drive_cfg) |-> (pad_oe == core_dir && pad_do == core_dat));
endmodule

// File: rtl/bscan_pin_cell.sv
module bscan_pin_cell
  import bscan_cell_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic tlr,
  input  logic ins_extest,
  input  logic ins_sample,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic scan_in,
  output logic scan_out,
  input  logic core_dat,
  input  logic core_dir,
  input  logic pullup_off_all,
  input  logic clk_drive_cfg,
  input  logic sys_clk,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_do,
  output logic pad_pullup
);
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] chain;
  logic [CHAIN_LEN-1:0] upd;

  assign cap_vec[CTL_POS] = core_dir;
  assign cap_vec[DAT_POS] = pad_in;

  bsc_scan_stages #(.N(CHAIN_LEN)) u_stages (
    .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .scan_in(scan_in), .cap_vec(cap_vec), .chain(chain), .scan_out(scan_out)
  );

  bsc_update_latch #(.N(CHAIN_LEN)) u_update (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .update_dr(update_dr),
    .chain(chain), .upd(upd)
  );

  bsc_pad_mux u_mux (
    .tck(tck), .rst_n(rst_n), .ins_extest(ins_extest), .ins_sample(ins_sample),
    .core_dat(core_dat), .core_dir(core_dir), .pullup_off_all(pullup_off_all),
    .clk_drive_cfg(clk_drive_cfg), .sys_clk(sys_clk),
    .upd_oe(upd[CTL_POS]), .upd_dat(upd[DAT_POS]),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pullup(pad_pullup)
  );

  // R10
  extest_drive_chk: assert property (@(posedge tck) disable iff (!rst_n)
    ins_extest |-> (pad_oe == upd[CTL_POS] && pad_do == upd[DAT_POS]));
  // R12
  tlr_undriven_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (ins_extest && tlr) |-> !pad_oe);
endmodule

// File: tb/bscan_pin_cell_bench.sv
module bscan_pin_cell_bench;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 0, ins_extest = 0, ins_sample = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, scan_in = 0;
  logic core_dat = 0, core_dir = 0, pullup_off_all = 0, clk_drive_cfg = 0;
  logic sys_clk = 0, pad_in = 0;
  logic scan_out, pad_oe, pad_do, pad_pullup;

  always #10 tck = ~tck;

  bscan_pin_cell u_bscan_pin_cell (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .ins_extest(ins_extest),
    .ins_sample(ins_sample), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .scan_in(scan_in), .scan_out(scan_out),
    .core_dat(core_dat), .core_dir(core_dir), .pullup_off_all(pullup_off_all),
    .clk_drive_cfg(clk_drive_cfg), .sys_clk(sys_clk), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pullup(pad_pullup)
  );

  typedef struct {
    string req;
    logic  oe, dat, pu, so;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 0;

  // independent model of the cell state
  bit m_ctl = 0, m_dat = 0, m_uoe = 0, m_udo = 0;
  bit p_cap = 0, p_sh = 0, p_si = 0, p_pin = 0, p_dir = 0;

  task automatic step(string req, bit ex, bit sm, bit cap, bit sh, bit up, bit tl,
                      bit si, bit pin, bit dir, bit dat, bit poff, bit cken, bit sclk);
    exp_t e;
    bit scan;
    @(posedge tck);
    if (p_cap) begin m_ctl = p_dir; m_dat = p_pin; end
    else if (p_sh) begin m_dat = m_ctl; m_ctl = p_si; end
    #2;
    ins_extest = ex; ins_sample = sm; capture_dr = cap; shift_dr = sh;
    update_dr = up; tlr = tl; scan_in = si; pad_in = pin; core_dir = dir;
    core_dat = dat; pullup_off_all = poff; clk_drive_cfg = cken; sys_clk = sclk;
    if (tl) begin m_uoe = 0; m_udo = 0; end
    else if (up) begin m_uoe = m_ctl; m_udo = m_dat; end
    scan = ex | sm;
    e.req = req;
    if (ex)               begin e.oe = m_uoe; e.dat = m_udo; end
    else if (!sm && cken) begin e.oe = 1'b1;  e.dat = sclk;  end
    else                  begin e.oe = dir;   e.dat = dat;   end
    e.pu = !scan && !poff && !dir && dat;
    e.so = m_dat;
    exp_q.push_back(e);
    p_cap = cap; p_sh = sh; p_si = si; p_pin = pin; p_dir = dir;
  endtask

  // monitor: samples after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(posedge tck);
      #15;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        vectors++;
        if (pad_oe !== e.oe || pad_do !== e.dat || pad_pullup !== e.pu || scan_out !== e.so) begin
          miscompares++;
          $display("FAIL %s: oe/do/pu/so actual %b%b%b%b expected %b%b%b%b", e.req,
                   pad_oe, pad_do, pad_pullup, scan_out, e.oe, e.dat, e.pu, e.so);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #2 rst_n = 1'b1;
    // R1 reset state seen under EXTEST
    step("R1", 1,0, 0,0,0,0, 0, 0, 1,1, 0,0,0);
    // R2 R3 functional pass-through and pull-up formula
    for (int v = 0; v < 8; v++)
      step("R2 R3", 0,0, 0,0,0,0, 0, 0, v[1],v[0], v[2],0,0);
    // R4 pull-up forced off in both scan modes
    for (int v = 0; v < 8; v++) begin
      step("R4", 0,1, 0,0,0,0, 0, 0, v[1],v[0], v[2],0,0);
      step("R4", 1,0, 0,0,0,0, 0, 0, v[1],v[0], v[2],0,0);
    end
    // R5 clock output in functional mode, suppressed under SAMPLE_PRELOAD
    step("R5", 0,0, 0,0,0,0, 0, 0, 0,1, 0,1,0);
    step("R5", 0,0, 0,0,0,0, 0, 0, 0,1, 0,1,1);
    step("R5", 0,1, 0,0,0,0, 0, 0, 0,1, 0,1,1);
    step("R5", 0,1, 0,0,0,0, 0, 0, 1,0, 0,1,1);
    // R6 R11 capture raw pad level and core direction under SAMPLE_PRELOAD
    step("R6 R11", 0,1, 1,0,0,0, 0, 1, 0,0, 0,0,0);
    step("R6 R11", 0,1, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R6", 0,1, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R6", 0,1, 1,0,0,0, 0, 0, 1,1, 0,0,0);
    step("R6", 0,1, 0,1,0,0, 1, 1, 0,0, 0,0,0);
    step("R6", 0,1, 0,0,0,0, 0, 1, 0,0, 0,0,0);
    // R7 shift walk
    step("R7", 0,1, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R7", 0,1, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R7", 0,1, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R7", 0,1, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R7", 0,1, 0,0,0,0, 0, 0, 0,0, 0,0,0);
    // R8 capture beats shift
    step("R8", 0,1, 1,1,0,0, 0, 0, 1,0, 0,0,0);
    step("R8", 0,1, 0,0,0,0, 0, 0, 0,0, 0,0,0);
    step("R8", 0,1, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    // R9 R10 preload 1/1 then update under EXTEST
    step("R9", 0,1, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R9", 0,1, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R9 R10", 1,0, 0,0,1,0, 0, 0, 0,0, 0,1,0);
    // R9 shifting without update leaves the pad alone
    step("R9", 1,0, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R9", 1,0, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R9", 1,0, 0,0,0,0, 0, 0, 1,0, 1,1,1);
    // R10 load ctl=1 dat=0, then ctl=0 dat=1
    step("R10", 1,0, 0,1,0,0, 0, 0, 0,0, 0,0,0);
    step("R10", 1,0, 0,1,0,0, 1, 0, 0,1, 0,0,0);
    step("R10", 1,0, 0,0,1,0, 0, 0, 0,1, 0,1,1);
    step("R10", 1,1, 0,1,0,0, 1, 1, 1,1, 0,0,0);
    step("R10", 1,1, 0,1,0,0, 0, 0, 1,1, 0,0,0);
    step("R10", 1,1, 0,0,1,0, 0, 0, 1,1, 0,0,0);
    // R12 tlr clears latches and overrides update
    step("R12", 1,0, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R12", 1,0, 0,1,0,0, 1, 0, 0,0, 0,0,0);
    step("R12", 1,0, 0,0,1,0, 0, 0, 0,0, 0,0,0);
    step("R12", 1,0, 0,0,1,1, 0, 0, 1,1, 0,0,0);
    step("R12", 1,0, 0,0,0,0, 0, 0, 1,1, 0,0,0);
    step("R12", 0,0, 0,0,0,0, 0, 0, 0,1, 0,0,0);
    repeat (3) @(posedge tck);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule